// File: doc/BRIEF.md
# Dual-lane halfword multiply unit

This execution unit takes one packed-halfword multiply instruction together with its two 32-bit source operands. It treats each operand as two signed 16-bit lanes and multiplies the upper lanes together and the lower lanes together. Each lane keeps a 16-bit result, and the two results are packed into one 32-bit destination value. An instruction bit chooses how a lane handles a product that does not fit in 16 bits. In the wrapping variant the lane keeps the low 16 bits. In the saturating variant the lane clips the product to the nearest signed 16-bit limit. When any lane overflows, the unit emits a set-mask for a sticky overflow bit, and the control register ORs that mask in.

The unit takes instructions on a valid/ready input and delivers each outcome through a one-entry registered output slot. An outcome is a result, a DSP-disabled exception or a reserved-instruction indication. An instruction is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the slot is empty, or when the slot is being drained in that same cycle (`out_ready` high). The slot drains on any edge where `out_ready` is high, whatever kind of outcome it holds. While `out_ready` is low, the slot contents and every output stay unchanged. The consumer applies the flag update on the same beat in which it takes the result.

Top module: `phmul_unit`

## Requirements
- R1: An instruction word matches only when bits 31..26 are 001000, bits 9..3 are 0000101 and bits 2..0 are 101. Any other word yields `exc_reserved` in the slot, with no `out_valid` and no flag update, whatever the value of `dsp_en`.
- R2: A matching word taken while `dsp_en` is low yields `exc_dsp_off`, with no `out_valid` and no flag update.
- R3: When bit 10 of the word is 0 (wrapping), result bits 31..16 are the low 16 bits of the signed product of `src_a[31:16]` and `src_b[31:16]`. Result bits 15..0 are formed the same way from bits 15..0 of the two operands.
- R4: When bit 10 is 1 (saturating), a lane product above 32767 gives 0x7FFF. A lane product below -32768 gives 0x8000. A product inside the range gives its low 16 bits. The boundary values 32767 and -32768 themselves pass through unclipped.
- R5: `flag_we` is high together with `out_valid` exactly when at least one lane product lies outside -32768..32767, in either variant. `flag_mask` is then 0x0020_0000 (bit 21 only). Otherwise `flag_we` is low and `flag_mask` is zero.
- R6: `out_dst` carries bits 15..11 of the instruction word that produced the result.
- R7: An instruction taken on one edge shows its outcome at the outputs immediately after the next edge.
- R8: `in_ready` is low exactly when the slot is full and `out_ready` is low. While the slot waits, its outputs hold. Outcomes leave in the order they were taken.
- R9: During reset and right after it, `out_valid`, `exc_dsp_off`, `exc_reserved` and `flag_we` are low.
- R10: At most one of `out_valid`, `exc_dsp_off` and `exc_reserved` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Unit can take an instruction this cycle |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand (two halfword lanes) |
| src_b | input | 32 | Second source operand (two halfword lanes) |
| dsp_en | input | 1 | DSP resources enabled |
| out_valid | output | 1 | Slot holds a result |
| out_ready | input | 1 | Consumer drains the slot this cycle |
| out_data | output | 32 | Packed halfword result |
| out_dst | output | 5 | Destination register index |
| flag_we | output | 1 | Overflow flag update present |
| flag_mask | output | 32 | Set-mask for the overflow flag (bit 21) |
| exc_dsp_off | output | 1 | Slot holds a DSP-disabled exception |
| exc_reserved | output | 1 | Slot holds a reserved-instruction indication |

## Verification
The assertions check several properties on every cycle. They check the one-cycle latency from acceptance to an outcome, and that a word with a wrong major opcode turns into a reserved indication. They check that a disabled unit never writes a result or the flag, and that the flag update only travels with a result. They also check that the three outcome kinds are mutually exclusive and that the slot holds steady while stalled. Only the bench scenarios can show that the lane arithmetic is correct. Those scenarios cover the exact clip values at and beyond the ±32768 boundaries, overflow in one lane only, wrap-versus-clip selection, destination index routing, and in-order delivery under a randomly stalling consumer.

// File: rtl/phmul_pkg.sv
package phmul_pkg;

  // Fixed opcode fields of the packed-halfword multiply word
  localparam logic [5:0] MAJOR_OP = 6'b001000;
  localparam logic [6:0] MINOR_OP = 7'b0000101;
  localparam logic [2:0] TAIL_OP  = 3'b101;

  localparam int unsigned INSTR_W   = 32;
  localparam int unsigned REG_IDX_W = 5;
  localparam int unsigned SAT_SEL   = 10;
  localparam int unsigned DST_LSB   = 11;

  typedef enum logic [1:0] {
    SLOT_RESULT   = 2'd0,
    SLOT_DSP_OFF  = 2'd1,
    SLOT_RESERVED = 2'd2
  } slot_kind_e;

  typedef struct packed {
    logic                 match;
    logic                 sat;
    logic [REG_IDX_W-1:0] dst;
  } decode_t;

endpackage

// File: rtl/phmul_decode.sv
module phmul_decode
  import phmul_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output decode_t            dec
);

  logic major_ok;
  logic minor_ok;
  logic tail_ok;
  logic unused_src_fields;

  always_comb begin
    major_ok  = (instr[31:26] == MAJOR_OP);
    minor_ok  = (instr[9:3]   == MINOR_OP);
    tail_ok   = (instr[2:0]   == TAIL_OP);
    dec.match = major_ok && minor_ok && tail_ok;
    dec.sat   = instr[SAT_SEL];
    dec.dst   = instr[DST_LSB +: REG_IDX_W];
  end

  // Source register indices are consumed by the register file, not here
  assign unused_src_fields = ^instr[25:16];

endmodule

// File: rtl/phmul_lane.sv
module phmul_lane #(
  parameter int unsigned LANE_W = 16
) (
  input  logic signed [LANE_W-1:0] op_x,
  input  logic signed [LANE_W-1:0] op_y,
  input  logic                     sat,
  output logic        [LANE_W-1:0] res,
  output logic                     ovf
);

  localparam int unsigned PROD_W = 2 * LANE_W;
  localparam logic signed [PROD_W-1:0] HI_LIM =
    {{(LANE_W + 1){1'b0}}, {(LANE_W - 1){1'b1}}};
  localparam logic signed [PROD_W-1:0] LO_LIM =
    {{(LANE_W + 1){1'b1}}, {(LANE_W - 1){1'b0}}};
  localparam logic [LANE_W-1:0] CLIP_POS = {1'b0, {(LANE_W - 1){1'b1}}};
  localparam logic [LANE_W-1:0] CLIP_NEG = {1'b1, {(LANE_W - 1){1'b0}}};

  logic signed [PROD_W-1:0] prod;
  logic                     above;
  logic                     below;

  always_comb begin
    prod  = op_x * op_y;
    above = (prod > HI_LIM);
    below = (prod < LO_LIM);
    ovf   = above || below;
    if (sat && above) begin
      res = CLIP_POS;
    end else if (sat && below) begin
      res = CLIP_NEG;
    end else begin
      res = prod[LANE_W-1:0];
    end
  end

endmodule

// File: rtl/phmul_datapath.sv
module phmul_datapath #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic                    sat,
  output logic [LANE_W*LANES-1:0] packed_res,
  output logic                    any_ovf
);

  logic [LANES-1:0] lane_ovf;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    phmul_lane #(.LANE_W(LANE_W)) lane_i (
      .op_x (src_a[l*LANE_W +: LANE_W]),
      .op_y (src_b[l*LANE_W +: LANE_W]),
      .sat  (sat),
      .res  (packed_res[l*LANE_W +: LANE_W]),
      .ovf  (lane_ovf[l])
    );
  end

  assign any_ovf = |lane_ovf;

endmodule

// File: rtl/phmul_slot.sv
module phmul_slot
  import phmul_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  slot_kind_e        kind_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic [IDX_W-1:0]  dst_in,
  input  logic              ovf_in,
  input  logic              drain,
  output logic              occ,
  output slot_kind_e        kind_q,
  output logic [DATA_W-1:0] data_q,
  output logic [IDX_W-1:0]  dst_q,
  output logic              ovf_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ <= 1'b0;
    end else if (load) begin
      occ <= 1'b1;
    end else if (drain) begin
      occ <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= SLOT_RESULT;
      ovf_q  <= 1'b0;
    end else if (load) begin
      kind_q <= kind_in;
      ovf_q  <= ovf_in;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      data_q <= data_in;
      dst_q  <= dst_in;
    end
  end

  // R8: a waiting slot keeps its contents
  a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (occ && !drain && !load) |=> (occ && $stable(data_q) && $stable(dst_q) && $stable(kind_q)));

endmodule

// File: rtl/phmul_unit.sv
module phmul_unit
  import phmul_pkg::*;
#(
  parameter int unsigned LANE_W   = 16,
  parameter int unsigned LANES    = 2,
  parameter int unsigned FLAG_BIT = 21
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [INSTR_W-1:0]        instr,
  input  logic [LANE_W*LANES-1:0]   src_a,
  input  logic [LANE_W*LANES-1:0]   src_b,
  input  logic                      dsp_en,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANE_W*LANES-1:0]   out_data,
  output logic [REG_IDX_W-1:0]      out_dst,
  output logic                      flag_we,
  output logic [LANE_W*LANES-1:0]   flag_mask,
  output logic                      exc_dsp_off,
  output logic                      exc_reserved
);

  localparam int unsigned DATA_W = LANE_W * LANES;
  localparam logic [DATA_W-1:0] FLAG_ONEHOT = DATA_W'(1) << FLAG_BIT;

  decode_t           dec;
  logic [DATA_W-1:0] lane_res;
  logic              lane_ovf;
  slot_kind_e        kind_in;
  logic              take;
  logic              occ;
  slot_kind_e        kind_q;
  logic              ovf_q;

  phmul_decode decode_i (
    .instr (instr),
    .dec   (dec)
  );

  phmul_datapath #(.LANE_W(LANE_W), .LANES(LANES)) datapath_i (
    .src_a      (src_a),
    .src_b      (src_b),
    .sat        (dec.sat),
    .packed_res (lane_res),
    .any_ovf    (lane_ovf)
  );

  // Reserved decode wins over the enable check
  always_comb begin
    if (!dec.match) begin
      kind_in = SLOT_RESERVED;
    end else if (!dsp_en) begin
      kind_in = SLOT_DSP_OFF;
    end else begin
      kind_in = SLOT_RESULT;
    end
  end

  assign in_ready = !occ || out_ready;
  assign take     = in_valid && in_ready;

  phmul_slot #(.DATA_W(DATA_W), .IDX_W(REG_IDX_W)) slot_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (take),
    .kind_in (kind_in),
    .data_in (lane_res),
    .dst_in  (dec.dst),
    .ovf_in  (lane_ovf && (kind_in == SLOT_RESULT)),
    .drain   (out_ready),
    .occ     (occ),
    .kind_q  (kind_q),
    .data_q  (out_data),
    .dst_q   (out_dst),
    .ovf_q   (ovf_q)
  );

  assign out_valid    = occ && (kind_q == SLOT_RESULT);
  assign exc_dsp_off  = occ && (kind_q == SLOT_DSP_OFF);
  assign exc_reserved = occ && (kind_q == SLOT_RESERVED);
  assign flag_we      = out_valid && ovf_q;
  assign flag_mask    = flag_we ? FLAG_ONEHOT : '0;

  // R7: one outcome follows every accepted instruction on the next cycle
  a_r7_outcome_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid || exc_dsp_off || exc_reserved));

  // R1: a wrong major opcode becomes a reserved indication
  a_r1_bad_major_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && instr[31:26] != MAJOR_OP) |=> (exc_reserved && !out_valid));

  // R2: disabled unit writes neither result nor flag
  a_r2_disabled_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !dsp_en) |=> (!out_valid && !flag_we));

  // R5: the flag update only travels with a result
  a_r5_flag_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |-> (out_valid && $countones(flag_mask) == 1));

  // R10: outcome kinds are exclusive
  a_r10_exclusive_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, exc_dsp_off, exc_reserved}));

  // R8: ready is withheld only while a full slot is not drained
  a_r8_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (!out_ready && (out_valid || exc_dsp_off || exc_reserved)));

endmodule

// File: tb/phmul_unit_tb.sv
module phmul_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] instr = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic        dsp_en = 1'b1;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic [4:0]  out_dst;
  logic        flag_we;
  logic [31:0] flag_mask;
  logic        exc_dsp_off;
  logic        exc_reserved;

  int n_checks = 0;
  int n_fails  = 0;
  bit ready_rand = 1'b0;
  bit ready_fixed = 1'b1;

  typedef struct {
    int          kind;   // 0 result, 1 dsp off, 2 reserved
    logic [31:0] data;
    logic [4:0]  dst;
    bit          flag;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #2.5 clk = ~clk;

  phmul_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .instr(instr), .src_a(src_a), .src_b(src_b), .dsp_en(dsp_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_dst(out_dst), .flag_we(flag_we), .flag_mask(flag_mask),
    .exc_dsp_off(exc_dsp_off), .exc_reserved(exc_reserved)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_word(input bit sat, input logic [4:0] rd);
    return {6'b001000, 5'd3, 5'd4, rd, sat, 7'b0000101, 3'b101};
  endfunction

  function automatic void lane_ref(input logic [15:0] x, input logic [15:0] y, input bit sat,
                                   output logic [15:0] r, output bit o);
    int p;
    p = int'($signed(x)) * int'($signed(y));
    o = (p > 32767) || (p < -32768);
    if (sat && p > 32767)       r = 16'h7FFF;
    else if (sat && p < -32768) r = 16'h8000;
    else                        r = p[15:0];
  endfunction

  function automatic exp_t model(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] b, input bit en, input string tag);
    exp_t e;
    bit ok, oh, ol;
    logic [15:0] rh, rl;
    ok = (w[31:26] == 6'b001000) && (w[9:3] == 7'b0000101) && (w[2:0] == 3'b101);
    lane_ref(a[31:16], b[31:16], w[10], rh, oh);
    lane_ref(a[15:0],  b[15:0],  w[10], rl, ol);
    e.tag  = tag;
    e.dst  = w[15:11];
    e.data = {rh, rl};
    e.flag = 1'b0;
    if (!ok)      e.kind = 2;
    else if (!en) e.kind = 1;
    else begin
      e.kind = 0;
      e.flag = oh || ol;
    end
    return e;
  endfunction

  // Driver: called at a falling edge, returns at the falling edge after acceptance
  task automatic send(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b,
                      input bit en, input string tag);
    instr = w; src_a = a; src_b = b; dsp_en = en; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    sb.push_back(model(w, a, b, en, tag));
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid || exc_dsp_off || exc_reserved, "R7 outcome one cycle later",
          {61'd0, out_valid, exc_dsp_off, exc_reserved}, 64'd1);
  endtask

  // Consumer ready pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    out_ready <= ready_rand ? (($urandom % 4) != 0) : ready_fixed;
  end

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      check(($countones({out_valid, exc_dsp_off, exc_reserved}) <= 1), "R10 exclusive kinds",
            {61'd0, out_valid, exc_dsp_off, exc_reserved}, 64'd0);
      if ((out_valid || exc_dsp_off || exc_reserved) && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected outcome", 64'd1, 64'd0);
        end else begin
          exp_t e;
          int act_kind;
          e = sb.pop_front();
          act_kind = out_valid ? 0 : (exc_dsp_off ? 1 : 2);
          check(act_kind == e.kind, {e.tag, " kind"}, act_kind, e.kind);
          if (e.kind == 0) begin
            check(out_data == e.data, {e.tag, " data"}, out_data, e.data);
            check(out_dst == e.dst, {e.tag, " R6 dst"}, out_dst, e.dst);
          end
          check(flag_we == e.flag, {e.tag, " R5 flag_we"}, flag_we, e.flag);
          check(flag_mask == (e.flag ? 32'h0020_0000 : 32'h0), {e.tag, " R5 flag_mask"},
                flag_mask, e.flag ? 32'h0020_0000 : 32'h0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 64'd0, 64'd1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!out_valid && !exc_dsp_off && !exc_reserved && !flag_we, "R9 reset state",
          {60'd0, out_valid, exc_dsp_off, exc_reserved, flag_we}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && !exc_dsp_off && !exc_reserved && !flag_we, "R9 after reset",
          {60'd0, out_valid, exc_dsp_off, exc_reserved, flag_we}, 64'd0);

    // R3 wrapping lanes
    send(mk_word(0, 5'd7),  32'h0003_0005, 32'h0004_FFFE, 1, "R3 small");
    send(mk_word(0, 5'd31), 32'h7FFF_8000, 32'h7FFF_8000, 1, "R3 wrap ovf");
    send(mk_word(0, 5'd1),  32'h8000_0100, 32'h0001_0100, 1, "R3 one lane ovf");
    // R4 saturating lanes and boundaries
    send(mk_word(1, 5'd2),  32'h7FFF_8000, 32'h7FFF_8000, 1, "R4 clip both pos");
    send(mk_word(1, 5'd3),  32'h8000_7FFF, 32'h7FFF_0001, 1, "R4 clip neg / exact max");
    send(mk_word(1, 5'd4),  32'h8000_4000, 32'h0001_0002, 1, "R4 exact min / just above");
    send(mk_word(1, 5'd5),  32'hFFFF_0010, 32'h8000_F000, 1, "R4 neg*neg / clip neg");
    send(mk_word(1, 5'd6),  32'h1234_0002, 32'h0002_FFFD, 1, "R4 in range");
    // R1 reserved words, R2 disabled
    send({6'b001001, mk_word(0, 5'd8)  & 32'h03FF_FFFF}, 32'h0, 32'h0, 1, "R1 bad major");
    send(mk_word(0, 5'd9)  ^ 32'h0000_0010, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 1, "R1 bad minor");
    send(mk_word(1, 5'd10) ^ 32'h0000_0001, 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, "R1 bad tail while off");
    send(mk_word(1, 5'd11), 32'h7FFF_7FFF, 32'h7FFF_7FFF, 0, "R2 disabled");

    // R8 back-pressure
    @(posedge clk); #1 ready_fixed = 1'b0;
    @(negedge clk);
    send(mk_word(0, 5'd12), 32'h0002_0003, 32'h0004_0005, 1, "R8 held item");
    check(!in_ready, "R8 ready low when full", in_ready, 64'd0);
    repeat (3) @(negedge clk);
    check(out_valid && out_data == 32'h0008_000F && out_dst == 5'd12, "R8 held output",
          out_data, 32'h0008_000F);
    @(posedge clk); #1 ready_fixed = 1'b1;
    @(negedge clk);

    // Random stream under a stalling consumer
    ready_rand = 1'b1;
    for (int i = 0; i < 300; i++) begin
      logic [31:0] w;
      int k;
      w = mk_word($urandom % 2, 5'($urandom));
      w[25:16] = 10'($urandom);
      if (($urandom % 8) == 0) begin
        k = $urandom % 16;
        k = (k < 10) ? k : 16 + k;
        w[k] = ~w[k];
      end
      send(w, $urandom, (($urandom % 3) == 0) ? 32'h8000_7FFF : $urandom,
           (($urandom % 10) != 0), "R3 R4 random");
    end
    ready_rand = 1'b0;
    repeat (10) @(negedge clk);
    check(sb.size() == 0, "R8 all outcomes delivered", sb.size(), 64'd0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule